// File: doc/BRIEF.md
# Resolver Bitstream Demodulator

This block turns the one-bit outputs of two delta-sigma modulators, one watching the sine winding of a resolver and one watching the cosine winding, into signed amplitude words with the excitation carrier removed. Each channel has the same chain. A third-order sinc decimator turns the bitstream into 14-bit words that still carry the carrier. Each word is multiplied by the sign of a carrier reference that has been delayed to match the filter. A decimating integrator then sums a fixed number of words, spanning a whole number of carrier periods.

The modulator bit rate is half the supplied clock. One sinc word is produced every OSR bits, so the defaults give one word every 256 clocks. The integrator length is chosen so that the carrier sits on a notch of the summing filter. The two output words share one valid strobe and are meant to feed an angle calculation downstream.

Top module: `resolver_bitstream_demod`

## Requirements
- R1: Both channels use identical filter chains driven by one shared bit enable and one shared decimation strobe, so the sine and cosine words always come out in the same clock cycle under one strobe.
- R2: A bit is taken on every second clock. A sinc word is formed once per OSR bits, which is every 2·OSR clocks. `amp_valid` pulses once every ACC_LEN·2·OSR clocks, which is 1024 clocks with the defaults.
- R3: An input bit of 1 counts as +1 and a bit of 0 counts as −1. A settled sinc word equals (2d−1)·2^(SINC_W−1) for a ones density d. With the defaults, density 3/4 gives +4096, density 1/4 gives −4096 and density 1/2 gives 0.
- R4: Sinc words saturate to the SINC_W range. All ones gives +8191 and all zeros gives −8192, so with ACC_LEN=4 and a positive reference the outputs are +32764 and −32768.
- R5: When `carrier_pos` is 1 the word is added unchanged. When it is 0 the word is negated. The reference applied to a word is the value that was sampled REF_DLY decimation instants before that word's own instant.
- R6: The integrator sums ACC_LEN demodulated words, presents the total with a one-cycle `amp_valid` pulse and clears. The outputs hold their value between pulses.
- R7: Take a reference that is a square wave with a period of ACC_LEN words, half of it at each level. With any constant input density, the output is 0 (carrier notch).
- R8: A synchronous active-high `rst` clears all state, forces the outputs to 0 and holds `amp_valid` low. After release, the first completed interval is not reported, so the first pulse comes more than ACC_LEN·2·OSR clocks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, twice the modulator bit rate |
| rst | input | 1 | Synchronous active-high reset |
| sin_bit | input | 1 | Sine-winding modulator bit |
| cos_bit | input | 1 | Cosine-winding modulator bit |
| carrier_pos | input | 1 | Carrier reference, 1 during the positive half-cycle |
| sin_amp | output | ACC_W (17) | Demodulated sine amplitude, signed |
| cos_amp | output | ACC_W (17) | Demodulated cosine amplitude, signed |
| amp_valid | output | 1 | One-cycle strobe marking new amplitude words |

## Verification
The assertions assume that the bit inputs and the reference change only away from the sampling edge, and that the reference is a clean binary level. The bench drives every input on the falling clock edge. It holds each bit for exactly two clocks and switches the reference only in whole multiples of 512 clocks. That makes each sinc word see one reference level and keeps the square wave aligned to word boundaries. Each check on a value is made only after two discarded output intervals, so filter transients and the reference delay have cleared before any exact value is compared.

// File: rtl/rbd_pkg.sv
package rbd_pkg;

   // Carrier half-cycle encoding shared by the alignment and demodulation stages.
   typedef enum logic {
      HALF_NEG = 1'b0,
      HALF_POS = 1'b1
   } carrier_half_e;

   // Internal width of a third-order sinc stage with one guard bit, so that
   // a full-scale result of +R^3 stays representable.
   function automatic int sinc3_width(input int log2_ratio);
      return 3 * log2_ratio + 2;
   endfunction

endpackage

// File: rtl/rbd_ref_align.sv
module rbd_ref_align #(
   parameter int DLY = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic sample,
   input  logic ref_in,
   output logic ref_out
);
   import rbd_pkg::*;

   generate
      if (DLY == 0) begin : g_direct
         carrier_half_e held;
         always_ff @(posedge clk) begin
            if (rst)         held <= HALF_NEG;
            else if (sample) held <= carrier_half_e'(ref_in);
         end
         assign ref_out = (held == HALF_POS);
      end else begin : g_line
         logic [DLY:0] line;
         always_ff @(posedge clk) begin
            if (rst)         line <= '0;
            else if (sample) line <= {line[DLY-1:0], ref_in};
         end
         assign ref_out = line[DLY];
      end
   endgenerate

endmodule

// File: rtl/rbd_sinc3.sv
module rbd_sinc3 #(
   parameter int OSR_LOG2 = 7,
   parameter int SINC_W   = 14
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     bit_en,
   input  logic                     dec_stb,
   input  logic                     bit_in,
   output logic signed [SINC_W-1:0] word,
   output logic                     word_stb
);
   import rbd_pkg::*;

   localparam int CIC_W = sinc3_width(OSR_LOG2);
   localparam int SHIFT = 3 * OSR_LOG2 - (SINC_W - 1);
   localparam logic signed [CIC_W-1:0] MAXV = (CIC_W'(1) <<< (SINC_W - 1)) - CIC_W'(1);
   localparam logic signed [CIC_W-1:0] MINV = -(CIC_W'(1) <<< (SINC_W - 1));

   generate
      if (SHIFT < 0) begin : g_chk_shift
         $error("SINC_W too wide for the chosen ratio");
      end
   endgenerate

   logic signed [CIC_W-1:0] x_ext, i1, i2, i3, d1, d2, d3, c1, c2, c3, scaled;
   logic signed [SINC_W-1:0] sat_word;

   assign x_ext = bit_in ? {{(CIC_W-1){1'b0}}, 1'b1} : {CIC_W{1'b1}};

   always_comb begin
      c1     = i3 - d1;
      c2     = c1 - d2;
      c3     = c2 - d3;
      scaled = c3 >>> SHIFT;
      if (scaled > MAXV)      sat_word = MAXV[SINC_W-1:0];
      else if (scaled < MINV) sat_word = MINV[SINC_W-1:0];
      else                    sat_word = scaled[SINC_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         i1 <= '0; i2 <= '0; i3 <= '0;
         d1 <= '0; d2 <= '0; d3 <= '0;
         word     <= '0;
         word_stb <= 1'b0;
      end else begin
         if (bit_en) begin
            i1 <= i1 + x_ext;
            i2 <= i2 + i1;
            i3 <= i3 + i2;
         end
         if (dec_stb) begin
            d1   <= i3;
            d2   <= c1;
            d3   <= c2;
            word <= sat_word;
         end
         word_stb <= dec_stb;
      end
   end

   AST_WORD_HOLD: assert property (@(posedge clk) disable iff (rst)
      !$past(dec_stb) |-> $stable(word)); // R2
   AST_WORD_STB_PULSE: assert property (@(posedge clk) disable iff (rst)
      word_stb |=> !word_stb); // R2

endmodule

// File: rtl/rbd_demod_integ.sv
module rbd_demod_integ #(
   parameter int SINC_W  = 14,
   parameter int ACC_LEN = 4,
   parameter int ACC_W   = 17
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     word_stb,
   input  logic signed [SINC_W-1:0] word,
   input  logic                     ref_pos,
   output logic signed [ACC_W-1:0]  amp,
   output logic                     amp_vld
);
   localparam int CNT_W = (ACC_LEN > 1) ? $clog2(ACC_LEN) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(ACC_LEN - 1);

   logic [CNT_W-1:0]        cnt;
   logic                    primed;
   logic signed [ACC_W-1:0] acc, word_ext, term, total;

   always_comb begin
      word_ext = {{(ACC_W-SINC_W){word[SINC_W-1]}}, word};
      term     = ref_pos ? word_ext : -word_ext;
      total    = acc + term;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt     <= '0;
         primed  <= 1'b0;
         acc     <= '0;
         amp     <= '0;
         amp_vld <= 1'b0;
      end else begin
         amp_vld <= 1'b0;
         if (word_stb) begin
            if (cnt == LAST) begin
               cnt    <= '0;
               acc    <= '0;
               primed <= 1'b1;
               if (primed) begin
                  amp     <= total;
                  amp_vld <= 1'b1;
               end
            end else begin
               cnt <= cnt + 1'b1;
               acc <= total;
            end
         end
      end
   end

   AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
      amp_vld |=> !amp_vld); // R6
   AST_AMP_HOLD: assert property (@(posedge clk) disable iff (rst)
      !amp_vld |-> $stable(amp)); // R6
   AST_VALID_ON_WORD: assert property (@(posedge clk) disable iff (rst)
      amp_vld |-> $past(word_stb)); // R6

endmodule

// File: rtl/resolver_bitstream_demod.sv
module resolver_bitstream_demod #(
   parameter int OSR     = 128,
   parameter int SINC_W  = 14,
   parameter int ACC_LEN = 4,
   parameter int REF_DLY = 2,
   localparam int ACC_W  = SINC_W + $clog2(ACC_LEN) + 1
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    sin_bit,
   input  logic                    cos_bit,
   input  logic                    carrier_pos,
   output logic signed [ACC_W-1:0] sin_amp,
   output logic signed [ACC_W-1:0] cos_amp,
   output logic                    amp_valid
);
   localparam int OSR_LOG2 = $clog2(OSR);
   localparam int N_CH     = 2;

   generate
      if ((1 << OSR_LOG2) != OSR || OSR < 2) begin : g_chk_osr
         $error("OSR must be a power of two of at least 2");
      end
      if (ACC_LEN < 1) begin : g_chk_len
         $error("ACC_LEN must be at least 1");
      end
      if (REF_DLY < 0) begin : g_chk_dly
         $error("REF_DLY must not be negative");
      end
   endgenerate

   logic                bit_en;
   logic [OSR_LOG2-1:0] bit_cnt;
   logic                dec_stb;
   logic                ref_aligned;

   always_ff @(posedge clk) begin
      if (rst) begin
         bit_en  <= 1'b0;
         bit_cnt <= '0;
      end else begin
         bit_en <= ~bit_en;
         if (bit_en) bit_cnt <= bit_cnt + 1'b1;
      end
   end

   assign dec_stb = bit_en && (&bit_cnt);

   rbd_ref_align #(.DLY(REF_DLY)) u_ref (
      .clk     (clk),
      .rst     (rst),
      .sample  (dec_stb),
      .ref_in  (carrier_pos),
      .ref_out (ref_aligned)
   );

   logic                    ch_bit   [N_CH];
   logic signed [SINC_W-1:0] ch_word [N_CH];
   logic                    ch_wstb  [N_CH];
   logic signed [ACC_W-1:0] ch_amp   [N_CH];
   logic                    ch_vld   [N_CH];

   assign ch_bit[0] = sin_bit;
   assign ch_bit[1] = cos_bit;

   generate
      for (genvar g = 0; g < N_CH; g++) begin : g_ch
         rbd_sinc3 #(.OSR_LOG2(OSR_LOG2), .SINC_W(SINC_W)) u_sinc (
            .clk      (clk),
            .rst      (rst),
            .bit_en   (bit_en),
            .dec_stb  (dec_stb),
            .bit_in   (ch_bit[g]),
            .word     (ch_word[g]),
            .word_stb (ch_wstb[g])
         );
         rbd_demod_integ #(.SINC_W(SINC_W), .ACC_LEN(ACC_LEN), .ACC_W(ACC_W)) u_integ (
            .clk      (clk),
            .rst      (rst),
            .word_stb (ch_wstb[g]),
            .word     (ch_word[g]),
            .ref_pos  (ref_aligned),
            .amp      (ch_amp[g]),
            .amp_vld  (ch_vld[g])
         );
      end
   endgenerate

   assign sin_amp   = ch_amp[0];
   assign cos_amp   = ch_amp[1];
   assign amp_valid = ch_vld[0];

   AST_CHAN_ALIGN: assert property (@(posedge clk) disable iff (rst)
      ch_vld[0] == ch_vld[1]); // R1
   AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (rst)
      ch_wstb[0] == ch_wstb[1]); // R1
   AST_RST_QUIET: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!amp_valid && sin_amp == '0 && cos_amp == '0)); // R8

endmodule

// File: tb/resolver_bitstream_demod_tb_top.sv
module resolver_bitstream_demod_tb_top;
   localparam int OSR      = 128;
   localparam int ACC_LEN  = 4;
   localparam int ACC_W    = 17;
   localparam int INTERVAL = ACC_LEN * 2 * OSR;
   localparam int NV       = 8;

   // Pattern bit k%4 drives bit k; ref mode: 0 negative, 1 positive, 2 square wave.
   localparam logic [3:0] SIN_PAT [NV] = '{4'b1111, 4'b1111, 4'b0111, 4'b0111,
                                          4'b0101, 4'b1111, 4'b0111, 4'b0011};
   localparam logic [3:0] COS_PAT [NV] = '{4'b0000, 4'b0000, 4'b0001, 4'b0001,
                                          4'b1010, 4'b0000, 4'b0001, 4'b1100};
   localparam int REF_MODE [NV] = '{1, 0, 1, 0, 1, 2, 2, 0};
   localparam int EXP_SIN  [NV] = '{32764, -32764, 16384, -16384, 0, 0, 0, 0};
   localparam int EXP_COS  [NV] = '{-32768, 32768, -16384, 16384, 0, 0, 0, 0};
   localparam string VREQ  [NV] = '{"R4", "R5", "R3", "R5", "R3", "R7", "R7", "R3"};

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic sin_bit = 1'b0;
   logic cos_bit = 1'b0;
   logic carrier_pos = 1'b0;
   logic signed [ACC_W-1:0] sin_amp, cos_amp;
   logic amp_valid;

   int n_checks = 0;
   int n_fail   = 0;
   logic [3:0] cur_sin = 4'b0101;
   logic [3:0] cur_cos = 4'b0101;
   int cur_ref = 1;

   always #2 clk = ~clk;

   resolver_bitstream_demod dut_i (
      .clk         (clk),
      .rst         (rst),
      .sin_bit     (sin_bit),
      .cos_bit     (cos_bit),
      .carrier_pos (carrier_pos),
      .sin_amp     (sin_amp),
      .cos_amp     (cos_amp),
      .amp_valid   (amp_valid)
   );

   // Input driver: one bit per two clocks, reference toggling every 512 clocks in square mode.
   initial begin
      int unsigned ncyc = 0;
      forever begin
         @(negedge clk);
         ncyc++;
         sin_bit <= cur_sin[(ncyc >> 1) % 4];
         cos_bit <= cur_cos[(ncyc >> 1) % 4];
         if (cur_ref == 2) carrier_pos <= ((ncyc / 512) % 2) == 0;
         else              carrier_pos <= (cur_ref == 1);
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wait_valid(output int waited);
      waited = 0;
      do begin
         @(posedge clk); #1;
         waited++;
      end while (!amp_valid);
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      finish_run();
   end

   initial begin
      int w;
      int gap;
      logic signed [ACC_W-1:0] held;
      repeat (4) @(posedge clk);
      #1;
      // R8: reset state
      check(amp_valid == 1'b0, "R8", int'(amp_valid), 0);
      check(sin_amp == '0, "R8", int'(sin_amp), 0);
      check(cos_amp == '0, "R8", int'(cos_amp), 0);
      @(negedge clk); rst <= 1'b0;
      // R8: first completed interval is withheld
      wait_valid(w);
      check(w > INTERVAL && w <= 2 * INTERVAL + 16, "R8", w, 2 * INTERVAL);

      for (int v = 0; v < NV; v++) begin
         @(negedge clk);
         cur_sin = SIN_PAT[v];
         cur_cos = COS_PAT[v];
         cur_ref = REF_MODE[v];
         wait_valid(w);
         wait_valid(w);
         wait_valid(gap);
         check(sin_amp == ACC_W'(EXP_SIN[v]), VREQ[v], int'(sin_amp), EXP_SIN[v]);
         check(cos_amp == ACC_W'(EXP_COS[v]), VREQ[v], int'(cos_amp), EXP_COS[v]);
         // R2: output period
         check(gap == INTERVAL, "R2", gap, INTERVAL);
         held = sin_amp;
         @(posedge clk); #1;
         // R6: single-cycle strobe
         check(amp_valid == 1'b0, "R6", int'(amp_valid), 0);
         repeat (300) @(posedge clk);
         #1;
         // R6: value held between strobes
         check(sin_amp == held, "R6", int'(sin_amp), int'(held));
      end

      // R1: both channels report on the same strobe (checked through shared valid and values above)
      check(sin_amp == '0 && cos_amp == '0, "R1", int'(cos_amp), 0);

      // R8: reset during operation
      @(negedge clk); rst <= 1'b1;
      repeat (2) @(posedge clk);
      #1;
      check(amp_valid == 1'b0 && sin_amp == '0 && cos_amp == '0, "R8", int'(sin_amp), 0);
      @(negedge clk);
      cur_sin = 4'b1111;
      rst <= 1'b0;
      wait_valid(w);
      check(w > INTERVAL, "R8", w, 2 * INTERVAL);
      finish_run();
   end

endmodule